// File: doc/BRIEF.md
# DRAM Clock Stop Controller

This block sits between a memory command scheduler and the clock and command pins of a low-power DDR memory. It passes commands from the scheduler to the memory one at a time. After each command it keeps the command bus at NOP until that command's completion window has run out. When the scheduler has nothing to send and stopping is enabled, it halts the differential memory clock. It restarts the clock as soon as new work arrives.

Each access command reloads a single down-counter with its own window length, taken from configuration inputs. A stop is considered only when that counter is zero, the idle-stop enable is set, no request is pending, and this idle condition has lasted for a programmable hysteresis count. Throughout, CKE stays high, so the memory remains in its idle or row-active state rather than entering power-down.

On restart, the controller holds the command bus at NOP for a programmable number of clock pulses, never fewer than one, before it grants the next command. The clock gate changes only while the internal clock is low, so every output pulse is a full high phase.

The controller is built as a state machine with three states: ST_RUN (clock running, commands granted), ST_STOPPED (clock halted) and ST_WAKE (clock running, NOP-only recovery). Its transitions are:

- RUN_TO_STOPPED, taken when the idle hysteresis expires.
- STOPPED_TO_WAKE, taken on a pending request or when the enable drops.
- WAKE_TO_RUN, taken when the NOP recovery count runs out.

Top module: `ckstop_ctrl`

## Requirements
- R1: After reset, `mem_cke` is 1, `mem_cmd` is NOP, `clk_stopped` is 0, `req_ready` is 1 and `mem_ck` toggles with `clk`.
- R2: Command codes are 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 REFRESH and 6 MODE-SET. The scheduler never presents codes 0 or 7. A request seen with `req_valid` and `req_ready` both high at a rising edge appears on `mem_cmd` directly after that edge.
- R3: Each command has a window of w cycles:
  - ACTIVATE uses `cfg_t_rcd`.
  - READ uses `cfg_t_rd`, which covers the data-out burst.
  - WRITE uses `cfg_t_wr`.
  - PRECHARGE uses `cfg_t_rp`.
  - REFRESH uses `cfg_t_rfc`.
  - MODE-SET uses `cfg_t_mrd`.

  After issue, `req_ready` stays low and `mem_cmd` stays NOP for w cycles. With a request waiting, the next command issues exactly w+1 cycles after the previous one.
- R4: The clock is never stopped while a window is running. With `stop_en` high and no request, `clk_stopped` rises exactly w+H+1 cycles after the last command's issue edge, where H is `cfg_idle_hyst`.
- R5: While `stop_en` is low, the clock is never stopped, however long the scheduler stays idle.
- R6: While stopped, `mem_ck` is 0, `mem_ck_n` is 1, `mem_cke` is 1, `mem_cmd` is NOP and `req_ready` is 0.
- R7: A request, or a drop of `stop_en`, seen while stopped clears `clk_stopped` at the very next edge.
- R8: After a restart, `req_ready` rises exactly N edges after the restart edge, with N = max(`cfg_nop_cycles`, 1). At least N `mem_ck` pulses carry NOP before the first command.
- R9: `mem_ck` changes its gating only during the low phase of `clk`: within any high phase of `clk` it is constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, source of the memory clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_en | input | 1 | Allows the clock to be stopped when idle |
| req_valid | input | 1 | Scheduler has a command pending |
| req_cmd | input | 3 | Pending command code |
| req_ready | output | 1 | Command will be accepted at this edge |
| cfg_t_rcd | input | CNT_W | Window after ACTIVATE, in cycles |
| cfg_t_rd | input | CNT_W | Window after READ including burst |
| cfg_t_wr | input | CNT_W | Window after WRITE |
| cfg_t_rp | input | CNT_W | Window after PRECHARGE |
| cfg_t_rfc | input | CNT_W | Window after REFRESH |
| cfg_t_mrd | input | CNT_W | Window after MODE-SET |
| cfg_nop_cycles | input | CNT_W | NOP pulses after restart (0 acts as 1) |
| cfg_idle_hyst | input | CNT_W | Idle cycles required before stopping |
| mem_ck | output | 1 | Gated true memory clock |
| mem_ck_n | output | 1 | Gated complementary memory clock |
| mem_cke | output | 1 | Clock enable, always high |
| mem_cmd | output | 3 | Registered command bus |
| clk_stopped | output | 1 | Memory clock is halted |

## Verification
The hardest situation to reach is the wake-up edge. It needs a stopped clock, which in turn needs an expired command window, an expired hysteresis count and a quiet scheduler all at once. The bench therefore issues a WRITE with a known window, raises `stop_en` and predicts the exact stop cycle. It then raises a request and counts NOP-carrying `mem_ck` pulses until the command appears. It repeats this wake-up with recovery counts of 0, 2 and 4, and also wakes the clock by dropping the enable instead of sending a request.

// File: rtl/ckstop_pkg.sv
package ckstop_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_MRS = 3'd6
    } mem_cmd_e;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_STOPPED = 2'd1,
        ST_WAKE    = 2'd2
    } ck_state_e;

endpackage

// File: rtl/ckstop_window_timer.sv
module ckstop_window_timer
    import ckstop_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [2:0]       cmd,
    input  logic [CNT_W-1:0] t_rcd,
    input  logic [CNT_W-1:0] t_rd,
    input  logic [CNT_W-1:0] t_wr,
    input  logic [CNT_W-1:0] t_rp,
    input  logic [CNT_W-1:0] t_rfc,
    input  logic [CNT_W-1:0] t_mrd,
    output logic             done
);
    logic [CNT_W-1:0] window;
    logic [CNT_W-1:0] remain_q;

    // Pick the completion window that belongs to the command being issued.
    always_comb begin
        unique case (cmd)
            CMD_ACT: window = t_rcd;
            CMD_RD:  window = t_rd;
            CMD_WR:  window = t_wr;
            CMD_PRE: window = t_rp;
            CMD_REF: window = t_rfc;
            CMD_MRS: window = t_mrd;
            default: window = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= window;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign done = (remain_q == '0);
endmodule

// File: rtl/ckstop_idle_filter.sv
module ckstop_idle_filter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle_ok,
    input  logic [CNT_W-1:0] hyst,
    output logic             expired
);
    logic [CNT_W-1:0] idle_cnt_q;

    // Counts consecutive idle cycles; any non-idle cycle starts over.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt_q <= '0;
        end else if (!idle_ok) begin
            idle_cnt_q <= '0;
        end else if (idle_cnt_q < hyst) begin
            idle_cnt_q <= idle_cnt_q + 1'b1;
        end
    end

    assign expired = idle_ok && (idle_cnt_q >= hyst);
endmodule

// File: rtl/ckstop_clk_gate.sv
module ckstop_clk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic run_req,
    output logic ck,
    output logic ck_n
);
    logic gate_en_q;

    // The enable is captured on the falling edge, so it only moves while clk is low.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_en_q <= 1'b1;
        end else begin
            gate_en_q <= run_req;
        end
    end

    assign ck   = clk & gate_en_q;
    assign ck_n = ~ck;
endmodule

// File: rtl/ckstop_ctrl.sv
module ckstop_ctrl
    import ckstop_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_en,
    input  logic             req_valid,
    input  logic [2:0]       req_cmd,
    output logic             req_ready,
    input  logic [CNT_W-1:0] cfg_t_rcd,
    input  logic [CNT_W-1:0] cfg_t_rd,
    input  logic [CNT_W-1:0] cfg_t_wr,
    input  logic [CNT_W-1:0] cfg_t_rp,
    input  logic [CNT_W-1:0] cfg_t_rfc,
    input  logic [CNT_W-1:0] cfg_t_mrd,
    input  logic [CNT_W-1:0] cfg_nop_cycles,
    input  logic [CNT_W-1:0] cfg_idle_hyst,
    output logic             mem_ck,
    output logic             mem_ck_n,
    output logic             mem_cke,
    output logic [2:0]       mem_cmd,
    output logic             clk_stopped
);
    localparam logic [CNT_W-1:0] NOP_MIN = CNT_W'(1);

    ck_state_e        state_q, state_d;
    logic [CNT_W-1:0] nop_left_q;
    logic [2:0]       cmd_q;
    logic             timer_done;
    logic             issue;
    logic             idle_ok;
    logic             stop_go;
    logic             wake_go;

    assign req_ready = (state_q == ST_RUN) && timer_done;
    assign issue     = req_valid && req_ready;
    assign idle_ok   = (state_q == ST_RUN) && stop_en && !req_valid && timer_done;
    assign wake_go   = req_valid || !stop_en;

    ckstop_window_timer #(.CNT_W(CNT_W)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (issue),
        .cmd   (req_cmd),
        .t_rcd (cfg_t_rcd),
        .t_rd  (cfg_t_rd),
        .t_wr  (cfg_t_wr),
        .t_rp  (cfg_t_rp),
        .t_rfc (cfg_t_rfc),
        .t_mrd (cfg_t_mrd),
        .done  (timer_done)
    );

    ckstop_idle_filter #(.CNT_W(CNT_W)) idle_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .idle_ok (idle_ok),
        .hyst    (cfg_idle_hyst),
        .expired (stop_go)
    );

    // Next-state logic for RUN_TO_STOPPED, STOPPED_TO_WAKE and WAKE_TO_RUN.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (stop_go) state_d = ST_STOPPED;
            ST_STOPPED: if (wake_go) state_d = ST_WAKE;
            ST_WAKE:    if (nop_left_q <= NOP_MIN) state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    // State register and NOP recovery counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_RUN;
            nop_left_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_STOPPED && state_d == ST_WAKE) begin
                nop_left_q <= cfg_nop_cycles;
            end else if (state_q == ST_WAKE && nop_left_q != '0) begin
                nop_left_q <= nop_left_q - 1'b1;
            end
        end
    end

    // Registered command bus: NOP on every cycle without an issue.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= CMD_NOP;
        end else begin
            cmd_q <= issue ? req_cmd : CMD_NOP;
        end
    end

    ckstop_clk_gate gate_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_req (state_q != ST_STOPPED),
        .ck      (mem_ck),
        .ck_n    (mem_ck_n)
    );

    assign mem_cmd     = cmd_q;
    assign mem_cke     = 1'b1;
    assign clk_stopped = (state_q == ST_STOPPED);
endmodule

// File: rtl/ckstop_ctrl_chk.sv
module ckstop_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stop_en,
    input logic       req_valid,
    input logic       req_ready,
    input logic       timer_done,
    input logic       clk_stopped,
    input logic [2:0] mem_cmd
);
    assert_cmd_needs_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd != 3'd0) |-> $past(req_valid && req_ready));

    assert_grant_after_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> timer_done);

    assert_stop_after_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_stopped) |-> $past(timer_done));

    assert_stop_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_stopped) |-> $past(stop_en && !req_valid));

    assert_nop_while_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stopped |-> (mem_cmd == 3'd0 && !req_ready));

    assert_no_grant_on_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_stopped) |-> !req_ready);
endmodule

bind ckstop_ctrl ckstop_ctrl_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_en     (stop_en),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .timer_done  (timer_done),
    .clk_stopped (clk_stopped),
    .mem_cmd     (mem_cmd)
);

// File: tb/ckstop_ctrl_tb_top.sv
`timescale 1ns/1ps
module ckstop_ctrl_tb_top;
    localparam int CNT_W = 8;
    localparam int HYST  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_en = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_cmd = 3'd0;
    logic req_ready;
    logic [CNT_W-1:0] t_rcd = 8'd3, t_rd = 8'd5, t_wr = 8'd6, t_rp = 8'd4, t_rfc = 8'd9, t_mrd = 8'd2;
    logic [CNT_W-1:0] nop_cycles = 8'd2;
    logic [CNT_W-1:0] hyst = 8'(HYST);
    logic mem_ck, mem_ck_n, mem_cke, clk_stopped;
    logic [2:0] mem_cmd;

    int n_tests = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ckstop_ctrl #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .stop_en(stop_en), .req_valid(req_valid),
        .req_cmd(req_cmd), .req_ready(req_ready),
        .cfg_t_rcd(t_rcd), .cfg_t_rd(t_rd), .cfg_t_wr(t_wr), .cfg_t_rp(t_rp),
        .cfg_t_rfc(t_rfc), .cfg_t_mrd(t_mrd), .cfg_nop_cycles(nop_cycles),
        .cfg_idle_hyst(hyst), .mem_ck(mem_ck), .mem_ck_n(mem_ck_n),
        .mem_cke(mem_cke), .mem_cmd(mem_cmd), .clk_stopped(clk_stopped)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int window_of(input logic [2:0] c);
        case (c)
            3'd1: return int'(t_rcd);
            3'd2: return int'(t_rd);
            3'd3: return int'(t_wr);
            3'd4: return int'(t_rp);
            3'd5: return int'(t_rfc);
            3'd6: return int'(t_mrd);
            default: return 0;
        endcase
    endfunction

    // R9: mem_ck is constant across every high phase of clk.
    int r9_bad = 0;
    always @(posedge clk) begin
        logic a;
        #1 a = mem_ck;
        #2 if (rst_n && mem_ck !== a) r9_bad++;
    end

    task automatic issue(input logic [2:0] c, output int at);
        @(negedge clk);
        req_valid = 1'b1;
        req_cmd   = c;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        at = cyc;
        req_valid = 1'b0;
        check("R2 command on bus", int'(mem_cmd), int'(c));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 cke", int'(mem_cke), 1);
        check("R1 cmd nop", int'(mem_cmd), 0);
        check("R1 not stopped", int'(clk_stopped), 0);
        check("R1 ready", int'(req_ready), 1);
        @(posedge clk);
        #1 check("R1 ck toggles", int'(mem_ck), 1);
    endtask

    task automatic t_spacing();
        for (int c = 1; c <= 6; c++) begin
            int c0, c1, w, nops;
            repeat (12) @(negedge clk);
            w = window_of(3'(c));
            issue(3'(c), c0);
            nops = 0;
            for (int k = 0; k < w; k++) begin
                @(posedge clk);
                #1 if (mem_cmd == 3'd0 && !req_ready) nops++;
                if (k == 0) nops += 0;
            end
            check($sformatf("R3 nop gap cmd %0d", c), nops, w > 0 ? w - 1 : 0);
        end
        for (int c = 1; c <= 6; c++) begin
            int c0, c1;
            repeat (12) @(negedge clk);
            issue(3'(c), c0);
            issue(3'd1, c1);
            check($sformatf("R3 spacing cmd %0d", c), c1 - c0, window_of(3'(c)) + 1);
        end
    endtask

    task automatic t_no_stop_disabled();
        int seen = 0;
        stop_en = 1'b0;
        repeat (40) begin
            @(posedge clk);
            #1 if (clk_stopped) seen++;
        end
        check("R5 never stops when disabled", seen, 0);
    endtask

    task automatic go_stop(output int stop_cyc);
        int c0, bad;
        issue(3'd3, c0);
        stop_en = 1'b1;
        bad = 0;
        stop_cyc = c0 + int'(t_wr) + HYST + 1;
        while (cyc < stop_cyc + 2) begin
            @(posedge clk);
            #1 if (int'(clk_stopped) != ((cyc >= stop_cyc) ? 1 : 0)) bad++;
        end
        check("R4 stop exactly after window and hysteresis", bad, 0);
    endtask

    task automatic t_stopped_levels();
        @(posedge clk);
        #1;
        check("R6 ck low", int'(mem_ck), 0);
        check("R6 ck_n high", int'(mem_ck_n), 1);
        check("R6 cke high", int'(mem_cke), 1);
        check("R6 cmd nop", int'(mem_cmd), 0);
        check("R6 not ready", int'(req_ready), 0);
    endtask

    task automatic t_wake(input int n_cfg);
        int stop_cyc, q, rdy_cyc, pulses, cmd_cyc, n_eff;
        nop_cycles = 8'(n_cfg);
        n_eff = (n_cfg < 1) ? 1 : n_cfg;
        go_stop(stop_cyc);
        repeat (3) @(negedge clk);
        req_valid = 1'b1;
        req_cmd   = 3'd1;
        @(posedge clk);
        #1 q = cyc;
        check($sformatf("R7 restart in one cycle nop=%0d", n_cfg), int'(clk_stopped), 0);
        pulses = 0;
        rdy_cyc = -1;
        cmd_cyc = -1;
        while (cmd_cyc < 0 && cyc < q + 40) begin
            @(posedge clk);
            #1;
            if (mem_cmd != 3'd0) cmd_cyc = cyc;
            else if (mem_ck) pulses++;
            if (rdy_cyc < 0 && req_ready) rdy_cyc = cyc;
        end
        req_valid = 1'b0;
        stop_en = 1'b0;
        check($sformatf("R8 ready edge nop=%0d", n_cfg), rdy_cyc - q, n_eff);
        check($sformatf("R8 command edge nop=%0d", n_cfg), cmd_cyc - q, n_eff + 1);
        check($sformatf("R8 nop pulses nop=%0d", n_cfg), (pulses >= n_eff) ? 1 : 0, 1);
    endtask

    task automatic t_wake_by_disable();
        int stop_cyc;
        go_stop(stop_cyc);
        t_stopped_levels();
        @(negedge clk);
        stop_en = 1'b0;
        @(posedge clk);
        #1 check("R7 restart on enable drop", int'(clk_stopped), 0);
        repeat (10) @(negedge clk);
        check("R5 stays running when disabled", int'(clk_stopped), 0);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_spacing();
        t_no_stop_disabled();
        t_wake(2);
        t_wake(0);
        t_wake(4);
        t_wake_by_disable();
        check("R9 no gate change in high phase", r9_bad, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule